// File: doc/BRIEF.md
# Byte-Aligned Scan Shift Engine

This block links a byte-wide processor-side register interface to a serial IEEE 1149.1 scan chain. It derives a test clock from the continuous system clock by gating it. A loaded byte goes out least significant bit first on the serial data output. Bits coming back from the chain are collected into a receive byte.

One 3-bit position counter sets the bit position for both the transmit and the receive shifter. The counter advances once per test-clock pulse. Every wrap of the counter is a byte boundary, and the engine stops itself at a boundary when it cannot go on. Returning serial data is sampled on the rising system-clock edge that coincides with a test-clock rising edge. The transmit bit changes on the falling edge, which is where the scan targets expect it.

The processor has four controls. It sets a run bit. It picks the active functions and the held TMS level in a mode register. It writes transmit bytes and pops received bytes. Two flags show whether the engine needs a new transmit byte and whether a received byte is waiting.

Top module: `scan_shift_engine`

## Requirements
- R1: After reset, `tx_empty` is 1, `rx_full` is 0, and `tck`, `tdo` and `tms` are 0. The position counter is 0.
- R2: `tck` follows the system clock high phase only in cycles where the engine is running. Otherwise it stays low. It never produces a pulse shorter than a full high phase.
- R3: The transmit byte goes out LSB first. `tdo` changes only on the falling clock edge. Bit n is valid at the n-th rising `tck` edge of the byte.
- R4: On each rising system-clock edge where `tck` rises, `tdi` is shifted in LSB first. This happens only if the receive function is enabled and `rx_full` is 0. The completed byte appears on `rd_data`.
- R5: The 3-bit position counter advances by one per `tck` pulse and wraps from 7 to 0. It holds its value while the clock is gated off.
- R6: A write to address 2 loads a transmit byte only while `tx_empty` is 1, and the load clears `tx_empty`. `tx_empty` sets again when the bit at counter position 7 has been sent.
- R7: `rx_full` sets when the counter wraps with the receive function enabled. A one-cycle `rd_en` pulse clears it.
- R8: With `run` set, the engine stops at the next byte boundary in three cases. The transmit function is enabled and `tx_empty` is set. The receive function is enabled and `rx_full` is set. Both apply. It resumes once the processor services the blocking buffer.
- R9: A function enabled while the counter is mid-byte handles only the positions left to the next boundary. A loaded transmitter started at count 3 sends 5 bits and then reports empty.
- R10: Address 1 is the mode register: bit 0 enables transmit, bit 1 enables receive, bit 2 is the TMS level. Writes to it are ignored while the test clock is running.
- R11: Address 0 bit 0 is `run`. The test clock runs only when `run` is 1, at least one function is enabled, and no enabled buffer blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Continuous system clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 mode, 2 transmit data) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Pop the received byte |
| rd_data | output | 8 | Last completed received byte |
| tx_empty | output | 1 | Transmit buffer needs a byte |
| rx_full | output | 1 | Received byte waiting |
| tck | output | 1 | Gated test clock |
| tms | output | 1 | Held TMS level |
| tdo | output | 1 | Serial data to the chain |
| tdi | input | 1 | Serial data from the chain |

## Verification
The engine is driven in four ways, each with a pseudo-random `tdi` stream that separates bit order and sample timing from constant data. In full-duplex runs, the stop must come from whichever buffer blocks first, and a transmit load and a receive pop must each resume clocking. A run is halted at count 3 and a transmitter is then enabled, which separates boundary-aligned loading from the short first byte. A receive-only stream with pops between bytes and a run with no function enabled check the start conditions. A mode write during clocking must leave `tms` and the shift pattern untouched.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_MODE = 2'd1,
        REG_TXD  = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic tms;
        logic rx_en;
        logic tx_en;
    } mode_t;

    localparam int unsigned MODE_W = $bits(mode_t);

    function automatic logic clock_allowed(
        input logic  run_req,
        input mode_t mode,
        input logic  tx_empty,
        input logic  rx_full
    );
        logic any_fn;
        logic blocked;
        any_fn  = mode.tx_en | mode.rx_en;
        blocked = (mode.tx_en & tx_empty) | (mode.rx_en & rx_full);
        return run_req & any_fn & ~blocked;
    endfunction

endpackage

// File: rtl/scan_clk_gate.sv
module scan_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    always_latch begin
        if (!clk) begin
            en_lat = en & ~rst;
        end
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/scan_bit_ctr.sv
module scan_bit_ctr #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned CNT_W = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            count <= (count == LAST) ? '0 : count + 1'b1;
        end
    end

    assign at_last = (count == LAST);
endmodule

// File: rtl/scan_tx_shifter.sv
module scan_tx_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wrap,
    input  logic              enable,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              empty,
    output logic              empty_nxt,
    output logic              tdo
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] sh_d;
    logic              shift_go;
    logic              load_ok;

    assign load_ok  = load & empty;
    assign shift_go = tick & enable & ~empty;

    always_comb begin
        sh_d      = sh_q;
        empty_nxt = empty;
        if (load_ok) begin
            sh_d      = load_data;
            empty_nxt = 1'b0;
        end else if (shift_go) begin
            sh_d = {1'b0, sh_q[DATA_W-1:1]};
            if (wrap) begin
                empty_nxt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            empty <= 1'b1;
        end else begin
            sh_q  <= sh_d;
            empty <= empty_nxt;
        end
    end

    // Output retimed to the falling edge so targets see it settle before rising tck.
    always_ff @(negedge clk) begin
        if (rst) begin
            tdo <= 1'b0;
        end else if (enable && !empty) begin
            tdo <= sh_q[0];
        end
    end
endmodule

// File: rtl/scan_rx_shifter.sv
module scan_rx_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wrap,
    input  logic              enable,
    input  logic              tdi,
    input  logic              pop,
    output logic              full,
    output logic              full_nxt,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] sh_q;
    logic [DATA_W-1:0] sh_in;
    logic              sample_en;

    assign sample_en = tick & enable & ~full;
    assign sh_in     = {tdi, sh_q[DATA_W-1:1]};

    always_comb begin
        full_nxt = full;
        if (pop) begin
            full_nxt = 1'b0;
        end
        if (sample_en && wrap) begin
            full_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
            data <= '0;
            full <= 1'b0;
        end else begin
            full <= full_nxt;
            if (sample_en) begin
                sh_q <= sh_in;
                if (wrap) begin
                    data <= sh_in;
                end
            end
        end
    end
endmodule

// File: rtl/scan_shift_engine.sv
module scan_shift_engine
    import scan_pkg::*;
#(
    parameter int unsigned DW = scan_pkg::DATA_W,
    localparam int unsigned CNT_W = $clog2(DW)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [scan_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]              wr_data,
    input  logic                       rd_en,
    output logic [DW-1:0]              rd_data,
    output logic                       tx_empty,
    output logic                       rx_full,
    output logic                       tck,
    output logic                       tms,
    output logic                       tdo,
    input  logic                       tdi
);
    mode_t            mode_q, mode_d;
    logic             run_req_q, run_req_d;
    logic             run_q;
    logic             tick;
    logic             wrap;
    logic             at_last;
    logic [CNT_W-1:0] cnt;
    logic             tx_empty_nxt;
    logic             rx_full_nxt;
    logic             wr_ctrl, wr_mode, wr_txd;

    assign wr_ctrl = wr_en && (reg_addr_e'(wr_addr) == REG_CTRL);
    assign wr_mode = wr_en && (reg_addr_e'(wr_addr) == REG_MODE);
    assign wr_txd  = wr_en && (reg_addr_e'(wr_addr) == REG_TXD);

    assign tick = run_q;
    assign wrap = tick & at_last;

    always_comb begin
        mode_d    = mode_q;
        run_req_d = run_req_q;
        if (wr_ctrl) begin
            run_req_d = wr_data[0];
        end
        if (wr_mode && !run_q) begin
            mode_d = mode_t'(wr_data[MODE_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= '0;
            run_req_q <= 1'b0;
            run_q     <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            run_req_q <= run_req_d;
            run_q     <= clock_allowed(run_req_d, mode_d, tx_empty_nxt, rx_full_nxt);
        end
    end

    scan_bit_ctr #(.DATA_W(DW)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .adv     (tick),
        .count   (cnt),
        .at_last (at_last)
    );

    scan_tx_shifter #(.DATA_W(DW)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wrap      (wrap),
        .enable    (mode_q.tx_en),
        .load      (wr_txd),
        .load_data (wr_data),
        .empty     (tx_empty),
        .empty_nxt (tx_empty_nxt),
        .tdo       (tdo)
    );

    scan_rx_shifter #(.DATA_W(DW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wrap     (wrap),
        .enable   (mode_q.rx_en),
        .tdi      (tdi),
        .pop      (rd_en),
        .full     (rx_full),
        .full_nxt (rx_full_nxt),
        .data     (rd_data)
    );

    scan_clk_gate u_gate (
        .clk  (clk),
        .rst  (rst),
        .en   (run_q),
        .gclk (tck)
    );

    assign tms = mode_q.tms;
endmodule

// File: rtl/scan_shift_engine_chk.sv
module scan_shift_engine_chk #(
    parameter int unsigned CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             run_q,
    input logic             run_req_q,
    input logic [2:0]       mode_q,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             tx_empty,
    input logic             rx_full
);
    localparam logic [CNT_W-1:0] LAST = '1;

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run_q |=> $stable(cnt));

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        run_q |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    // R7
    rx_full_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> ($past(run_q) && $past(cnt) == LAST));

    // R6
    tx_empty_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> ($past(run_q) && $past(cnt) == LAST));

    // R10
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && wr_en && wr_addr == 2'd1) |=> $stable(mode_q));

    // R8
    stop_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run_q) |-> (cnt == '0 || !run_req_q));
endmodule

bind scan_shift_engine scan_shift_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt       (cnt),
    .run_q     (run_q),
    .run_req_q (run_req_q),
    .mode_q    (mode_q),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .tx_empty  (tx_empty),
    .rx_full   (rx_full)
);

// File: tb/scan_shift_engine_tb.sv
`timescale 1ns/1ps
module scan_shift_engine_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, tck, tms, tdo;
    logic       tdi = 1'b0;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [15:0] lfsr = 16'hACE1;

    // reference state
    int   m_cnt = 0;
    bit   m_run = 0, m_req = 0, m_txen = 0, m_rxen = 0, m_tms = 0;
    bit   m_txe = 1, m_rxf = 0, m_tdo = 0;
    int   m_txsh = 0, m_rxsh = 0, m_rxbuf = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    scan_shift_engine u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .tx_empty(tx_empty), .rx_full(rx_full),
        .tck(tck), .tms(tms), .tdo(tdo), .tdi(tdi)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic model_step();
        int  n_cnt = m_cnt, n_txsh = m_txsh, n_rxsh = m_rxsh, n_rxbuf = m_rxbuf;
        bit  n_txe = m_txe, n_rxf = m_rxf, n_req = m_req;
        bit  n_txen = m_txen, n_rxen = m_rxen, n_tms = m_tms;
        if (m_run) begin
            n_cnt = (m_cnt + 1) % 8;
            if (m_txen && !m_txe) begin
                n_txsh = m_txsh >> 1;
                if (m_cnt == 7) n_txe = 1;
            end
            if (m_rxen && !m_rxf) begin
                n_rxsh = (m_rxsh >> 1) | (int'(tdi) << 7);
                if (m_cnt == 7) begin n_rxbuf = n_rxsh; n_rxf = 1; end
            end
        end
        if (rd_en) n_rxf = (m_run && m_rxen && !m_rxf && m_cnt == 7);
        if (wr_en && wr_addr == 0) n_req = wr_data[0];
        if (wr_en && wr_addr == 1 && !m_run) begin
            n_txen = wr_data[0]; n_rxen = wr_data[1]; n_tms = wr_data[2];
        end
        if (wr_en && wr_addr == 2 && m_txe) begin n_txsh = wr_data; n_txe = 0; end
        m_run = n_req && (n_txen || n_rxen) && !(n_txen && n_txe) && !(n_rxen && n_rxf);
        m_cnt = n_cnt; m_txsh = n_txsh; m_rxsh = n_rxsh; m_rxbuf = n_rxbuf;
        m_txe = n_txe; m_rxf = n_rxf; m_req = n_req;
        m_txen = n_txen; m_rxen = n_rxen; m_tms = n_tms;
        if (m_txen && !m_txe) m_tdo = m_txsh[0];
    endtask

    task automatic step();
        bit exp_tck;
        @(negedge clk); #4;
        chk("R3 tdo", tdo, m_tdo);
        chk("R4 rd_data", rd_data, m_rxbuf);
        chk("R7 rx_full", rx_full, m_rxf);
        chk("R6 tx_empty", tx_empty, m_txe);
        chk("R10 tms", tms, m_tms);
        chk("R2 tck low phase", tck, 0);
        exp_tck = m_run;
        model_step();
        @(posedge clk); #1;
        chk("R2 tck high phase", tck, exp_tck);
        if (tck) pulses++;
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tdi = lfsr[0];
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0;
    endtask

    task automatic pop();
        rd_en = 1; step(); rd_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3 rst = 0;
        // R1 reset state
        @(negedge clk); #4;
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 tdo", tdo, 0);
        chk("R1 tms", tms, 0);
        chk("R1 tck", tck, 0);
        @(posedge clk); #3;

        // full duplex byte, stop on both buffers (R8)
        wr(1, 8'h03);
        wr(2, 8'hA5);
        pulses = 0;
        wr(0, 8'h01);
        idle(14);
        chk("R8 pulses per byte", pulses, 8);
        chk("R5 R4 rx byte ready", rx_full, 1);
        pop();
        pulses = 0;
        idle(4);
        chk("R8 tx empty still blocks", pulses, 0);
        wr(2, 8'h3C);
        wr(1, 8'h04);            // R10 ignored while clocking
        idle(12);
        chk("R10 tms unchanged", tms, 0);
        chk("R8 resumed byte", pulses, 8);
        wr(2, 8'hFF);            // accepted (empty), blocked by rx full
        wr(2, 8'h11);            // R6 ignored: buffer not empty
        pop();
        idle(12);

        // short first byte (R9)
        pop();
        wr(1, 8'h02);            // rx only, run still requested
        idle(2);
        wr(0, 8'h00);            // halts at count 3
        wr(1, 8'h01);
        pulses = 0;
        wr(2, 8'h96);
        wr(0, 8'h01);
        idle(12);
        chk("R9 short byte pulses", pulses, 5);
        chk("R9 empty after short byte", tx_empty, 1);

        // rx-only stream with pops (R4, R7)
        wr(1, 8'h02);
        for (int b = 0; b < 3; b++) begin
            idle(10);
            chk("R7 full before pop", rx_full, 1);
            pop();
        end
        wr(0, 8'h00);
        idle(10);

        // no function enabled (R11), tms level (R10)
        wr(1, 8'h04);
        pulses = 0;
        wr(0, 8'h01);
        idle(10);
        chk("R11 no clock without function", pulses, 0);
        chk("R10 tms set", tms, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule